// File: doc/BRIEF.md
# LCD Address Window Command Generator

This block turns a window start point and a rotation selection into the short command sequence that a page-organized grayscale LCD controller needs before pixel data can be streamed. A page holds two pixel rows, so the page address is the row coordinate halved. For quarter-turn rotations the horizontal and vertical coordinates exchange roles. Each rotation also selects its own scan-order and mirroring settings.

A request is presented with `req_valid`, a start coordinate and a rotation code, and is taken when `req_ready` is high. The block then produces six command bytes on a valid/ready byte stream. The order is a RAM scan-order command, a display mapping command, two column address bytes and two page address bytes. `cmd_last` marks the final byte. Coordinates beyond the panel are limited to its last column or row before encoding.

Top module: `lcd_window_cmd_gen`

## Requirements
- R1: After a synchronous active-low reset, `req_ready` is 1 and `cmd_valid` is 0.
- R2: An accepted request yields exactly six bytes in this order: scan-order command, mapping command, column low, column high, page low, page high. `cmd_last` is 1 only on the sixth byte.
- R3: The scan-order byte is 0x89 for rotation codes 0 (0 deg) and 2 (180 deg). It is 0x8B for codes 1 (90 deg) and 3 (270 deg). Bit 1 selects page-first stepping, bit 0 selects wrap-around, and bit 2 (decrement) is always 0.
- R4: The mapping byte is 0xC2 for code 0, 0xC0 for code 1, 0xC4 for code 2 and 0xC6 for code 3. Bit 2 is vertical mirror, bit 1 is horizontal mirror, and bit 0 is always 0.
- R5: The column bytes are 0x00|col[3:0] followed by 0x10|(col>>4). The column source is x for codes 0 and 2 and y for codes 1 and 3.
- R6: The page bytes are 0x60|((row>>1)&0xF) followed by 0x70|(row>>5). The row source is y for codes 0 and 2 and x for codes 1 and 3.
- R7: An x above 239 is encoded as 239 and a y above 159 is encoded as 159. This limiting happens before the coordinates exchange roles.
- R8: While `cmd_valid` is 1 and `cmd_ready` is 0, `cmd_data` and `cmd_last` hold steady. The stream advances only on a handshake.
- R9: `req_ready` is 1 only while no sequence is in progress. This includes the cycle in which the final byte is handed over. `req_ready` returns to 1 in the cycle after that handshake.
- R10: Coordinates and rotation are captured when the request is accepted. Changing the request inputs during a sequence has no effect on its bytes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request will be taken |
| req_x | input | COORD_W | Window start, horizontal |
| req_y | input | COORD_W | Window start, vertical |
| req_rot | input | 2 | Rotation code: 0, 1, 2, 3 = 0, 90, 180, 270 deg |
| cmd_valid | output | 1 | Command byte present |
| cmd_ready | input | 1 | Receiver takes the byte |
| cmd_data | output | 8 | Command byte |
| cmd_last | output | 1 | Final byte of the sequence |

## Verification
Two events can fall in the same cycle: a new request arriving and the final byte of the current sequence being handed over. The bench provokes this by holding `req_valid` high with the next request's values for the whole of a sequence, under random backpressure. It then checks that `req_ready` stays low through the final handshake and rises exactly one cycle later. It also checks that the first sequence's bytes still reflect the captured values and that the held request produces its own correct six bytes.

// File: rtl/lcd_window_cmd_pkg.sv
// Shared types and helpers for the LCD address window command generator.
// Assumes an 8-bit command byte and a 2-bit rotation code.
package lcd_window_cmd_pkg;

    // Position inside the six-byte command sequence
    typedef enum logic [2:0] {
        STEP_SCAN   = 3'd0,
        STEP_MAP    = 3'd1,
        STEP_COL_LO = 3'd2,
        STEP_COL_HI = 3'd3,
        STEP_PG_LO  = 3'd4,
        STEP_PG_HI  = 3'd5
    } step_t;

    // Rotation codes
    typedef enum logic [1:0] {
        ROT_0   = 2'd0,
        ROT_90  = 2'd1,
        ROT_180 = 2'd2,
        ROT_270 = 2'd3
    } rot_t;

    localparam logic [7:0] OP_SCAN   = 8'h88;
    localparam logic [7:0] OP_MAP    = 8'hC0;
    localparam logic [7:0] OP_COL_LO = 8'h00;
    localparam logic [7:0] OP_COL_HI = 8'h10;
    localparam logic [7:0] OP_PG_LO  = 8'h60;
    localparam logic [7:0] OP_PG_HI  = 8'h70;

    // Mirror bits {vertical, horizontal} for a rotation
    function automatic logic [1:0] mirror_bits(input rot_t r);
        case (r)
            ROT_0:   return 2'b01;
            ROT_90:  return 2'b00;
            ROT_180: return 2'b10;
            default: return 2'b11;
        endcase
    endfunction

endpackage

// File: rtl/lcd_window_coord_map.sv
// Coordinate mapper: limits x and y to the panel, then selects which one
// is the column and which the row for the requested rotation.
// Assumes PANEL_W and PANEL_H both fit in COORD_W bits.
module lcd_window_coord_map
    import lcd_window_cmd_pkg::*;
#(
    parameter int COORD_W = 8,
    parameter int PANEL_W = 240,
    parameter int PANEL_H = 160
) (
    input  logic [COORD_W-1:0] in_x,
    input  logic [COORD_W-1:0] in_y,
    input  rot_t               in_rot,
    output logic [COORD_W-1:0] out_col,
    output logic [COORD_W-1:0] out_row
);
    localparam logic [COORD_W-1:0] X_MAX = COORD_W'(PANEL_W - 1);
    localparam logic [COORD_W-1:0] Y_MAX = COORD_W'(PANEL_H - 1);

    logic [COORD_W-1:0] lim_x;
    logic [COORD_W-1:0] lim_y;
    logic               swap;

    // Limit each coordinate to the last pixel of the panel
    always_comb begin
        lim_x = (in_x > X_MAX) ? X_MAX : in_x;
        lim_y = (in_y > Y_MAX) ? Y_MAX : in_y;
    end

    // Quarter-turn rotations exchange the roles of x and y
    always_comb begin
        swap    = (in_rot == ROT_90) || (in_rot == ROT_270);
        out_col = swap ? lim_y : lim_x;
        out_row = swap ? lim_x : lim_y;
    end
endmodule

// File: rtl/lcd_window_byte_enc.sv
// Byte encoder: produces the command byte for one step of the sequence
// from the captured column, row and rotation. Pure combinational.
// Assumes col>>4 and row>>5 fit in four bits at COORD_W = 8.
module lcd_window_byte_enc
    import lcd_window_cmd_pkg::*;
#(
    parameter int COORD_W = 8
) (
    input  logic [COORD_W-1:0] col,
    input  logic [COORD_W-1:0] row,
    input  rot_t               rot,
    input  step_t              step,
    output logic [7:0]         data
);
    logic [COORD_W-1:0] col_hi;
    logic [COORD_W-1:0] pg_lo;
    logic [COORD_W-1:0] pg_hi;
    logic               page_first;
    logic [1:0]         mir;

    // Derive the address fields and the rotation-dependent control bits
    always_comb begin
        col_hi     = col >> 4;
        pg_lo      = row >> 1;
        pg_hi      = row >> 5;
        page_first = rot[0];
        mir        = mirror_bits(rot);
    end

    // Select the opcode and field for the current step
    always_comb begin
        case (step)
            STEP_SCAN:   data = OP_SCAN | {5'b0, 1'b0, page_first, 1'b1};
            STEP_MAP:    data = OP_MAP | {5'b0, mir, 1'b0};
            STEP_COL_LO: data = OP_COL_LO | {4'h0, col[3:0]};
            STEP_COL_HI: data = OP_COL_HI | {4'h0, col_hi[3:0]};
            STEP_PG_LO:  data = OP_PG_LO | {4'h0, pg_lo[3:0]};
            default:     data = OP_PG_HI | {4'h0, pg_hi[3:0]};
        endcase
    end
endmodule

// File: rtl/lcd_window_seq.sv
// Sequencer: walks the six command steps, advancing one step per output
// handshake, and reports busy while a sequence is in progress.
// Assumes start is only honoured while idle.
module lcd_window_seq
    import lcd_window_cmd_pkg::*;
#(
    parameter int NUM_STEPS = 6
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  start,
    input  logic  out_ready,
    output logic  busy,
    output step_t step,
    output logic  last
);
    localparam step_t FINAL_STEP = step_t'(NUM_STEPS - 1);

    logic fire;

    // An output handshake happens whenever busy meets ready
    always_comb begin
        fire = busy && out_ready;
        last = busy && (step == FINAL_STEP);
    end

    // Step counter and busy flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            step <= STEP_SCAN;
        end else if (!busy) begin
            if (start) begin
                busy <= 1'b1;
                step <= STEP_SCAN;
            end
        end else if (fire) begin
            if (step == FINAL_STEP) begin
                busy <= 1'b0;
                step <= STEP_SCAN;
            end else begin
                step <= step_t'(step + 3'd1);
            end
        end
    end
endmodule

// File: rtl/lcd_window_cmd_gen.sv
// Top: accepts a window start and rotation, captures the mapped column and
// row, and streams six command bytes with a valid/ready handshake.
// Assumes the receiver obeys the valid/ready rules.
module lcd_window_cmd_gen
    import lcd_window_cmd_pkg::*;
#(
    parameter int COORD_W = 8,
    parameter int PANEL_W = 240,
    parameter int PANEL_H = 160
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [COORD_W-1:0] req_x,
    input  logic [COORD_W-1:0] req_y,
    input  logic [1:0]         req_rot,
    output logic               cmd_valid,
    input  logic               cmd_ready,
    output logic [7:0]         cmd_data,
    output logic               cmd_last
);
    logic [COORD_W-1:0] map_col;
    logic [COORD_W-1:0] map_row;
    logic [COORD_W-1:0] cap_col;
    logic [COORD_W-1:0] cap_row;
    rot_t               cap_rot;
    logic               busy;
    logic               accept;
    step_t              step;

    lcd_window_coord_map #(
        .COORD_W(COORD_W),
        .PANEL_W(PANEL_W),
        .PANEL_H(PANEL_H)
    ) u_map (
        .in_x   (req_x),
        .in_y   (req_y),
        .in_rot (rot_t'(req_rot)),
        .out_col(map_col),
        .out_row(map_row)
    );

    lcd_window_seq #(
        .NUM_STEPS(6)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (req_valid),
        .out_ready(cmd_ready),
        .busy     (busy),
        .step     (step),
        .last     (cmd_last)
    );

    lcd_window_byte_enc #(
        .COORD_W(COORD_W)
    ) u_enc (
        .col (cap_col),
        .row (cap_row),
        .rot (cap_rot),
        .step(step),
        .data(cmd_data)
    );

    // Request side is open only while idle
    always_comb begin
        req_ready = !busy;
        accept    = req_valid && req_ready;
        cmd_valid = busy;
    end

    // Capture the mapped coordinates and rotation on acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_col <= '0;
            cap_row <= '0;
            cap_rot <= ROT_0;
        end else if (accept) begin
            cap_col <= map_col;
            cap_row <= map_row;
            cap_rot <= rot_t'(req_rot);
        end
    end
endmodule

// File: rtl/lcd_window_cmd_chk.sv
// Checker for the LCD address window command generator, bound to the top.
module lcd_window_cmd_chk #(
    parameter int COORD_W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         req_valid,
    input logic         req_ready,
    input logic         cmd_valid,
    input logic         cmd_ready,
    input logic [7:0]   cmd_data,
    input logic         cmd_last
);
    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_data) && $stable(cmd_last));

    assert_idle_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_ready && cmd_valid));

    assert_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_ready && cmd_last |=> req_ready && !cmd_valid);

    assert_first_scan_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> cmd_valid && cmd_data[7:4] == 4'h8 && !cmd_last);

    assert_scan_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_data[7:4] == 4'h8 |-> cmd_data[3] && !cmd_data[2] && cmd_data[0]);

    assert_map_bits_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_data[7:4] == 4'hC |-> !cmd_data[3] && !cmd_data[0]);

    assert_last_page_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_last |-> cmd_data[7:4] == 4'h7);

    assert_col_limit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_data[7:4] == 4'h1 |-> cmd_data[3:0] <= 4'hE);
endmodule

bind lcd_window_cmd_gen lcd_window_cmd_chk #(.COORD_W(COORD_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_ready(req_ready),
    .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready),
    .cmd_data (cmd_data),
    .cmd_last (cmd_last)
);

// File: tb/sim_lcd_window_cmd_gen.sv
module sim_lcd_window_cmd_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic [7:0] req_x = '0;
    logic [7:0] req_y = '0;
    logic [1:0] req_rot = '0;
    logic       cmd_valid;
    logic       cmd_ready = 1'b0;
    logic [7:0] cmd_data;
    logic       cmd_last;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    lcd_window_cmd_gen u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_x(req_x), .req_y(req_y), .req_rot(req_rot), .cmd_valid(cmd_valid),
        .cmd_ready(cmd_ready), .cmd_data(cmd_data), .cmd_last(cmd_last)
    );

    // Expected byte computed from the requirements
    function automatic logic [7:0] exp_byte(input logic [7:0] x, input logic [7:0] y,
                                            input logic [1:0] r, input int idx);
        logic [7:0] cx, cy, col, row;
        cx  = (x > 8'd239) ? 8'd239 : x;            // R7
        cy  = (y > 8'd159) ? 8'd159 : y;
        col = r[0] ? cy : cx;                       // R5
        row = r[0] ? cx : cy;                       // R6
        case (idx)
            0: return r[0] ? 8'h8B : 8'h89;         // R3
            1: case (r)                             // R4
                   2'd0: return 8'hC2;
                   2'd1: return 8'hC0;
                   2'd2: return 8'hC4;
                   default: return 8'hC6;
               endcase
            2: return {4'h0, col[3:0]};
            3: return 8'h10 | (col >> 4);
            4: return 8'h60 | ((row >> 1) & 8'h0F);
            default: return 8'h70 | (row >> 5);
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Runs one request from a negedge; leaves at the negedge after the last byte.
    // keep=1 holds req_valid with the next triple during the stream.
    task automatic do_req(input logic [7:0] x, input logic [7:0] y, input logic [1:0] r,
                          input bit bp, input bit keep,
                          input logic [7:0] nx, input logic [7:0] ny, input logic [1:0] nr);
        int idx;
        int guard;
        req_valid = 1'b1; req_x = x; req_y = y; req_rot = r;
        check(req_ready == 1'b1, "R9 idle ready", int'(req_ready), 1);
        @(negedge clk);
        if (keep) begin
            req_x = nx; req_y = ny; req_rot = nr;
        end else begin
            req_valid = 1'b0;
            req_x = 8'($urandom); req_y = 8'($urandom); req_rot = 2'($urandom); // R10
        end
        idx = 0;
        guard = 0;
        while (idx < 6 && guard < 400) begin
            guard++;
            cmd_ready = bp ? 1'($urandom % 2) : 1'b1;
            check(req_ready == 1'b0, "R9 busy blocks request", int'(req_ready), 0);
            check(cmd_valid == 1'b1, "R2 valid during sequence", int'(cmd_valid), 1);
            if (cmd_valid) begin
                // R2 R8 R10: byte value and last flag, held or handed over
                check(cmd_data == exp_byte(x, y, r, idx), "R2 byte",
                      int'(cmd_data), int'(exp_byte(x, y, r, idx)));
                check(cmd_last == (idx == 5), "R2 last flag", int'(cmd_last), int'(idx == 5));
                if (cmd_ready) idx++;
            end
            @(negedge clk);
        end
        check(idx == 6, "R2 six bytes", idx, 6);
        cmd_ready = 1'b0;
        check(req_ready == 1'b1 && cmd_valid == 1'b0, "R9 release",
              int'({req_ready, cmd_valid}), 2);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1 && cmd_valid == 1'b0, "R1 reset state",
              int'({req_ready, cmd_valid}), 2);

        // Directed corners for each rotation
        for (int r = 0; r < 4; r++) begin
            do_req(8'd0, 8'd0, 2'(r), 1'b0, 1'b0, 0, 0, 0);            // R3 R4
            do_req(8'd239, 8'd159, 2'(r), 1'b0, 1'b0, 0, 0, 0);        // R5 R6
            do_req(8'd240, 8'd160, 2'(r), 1'b1, 1'b0, 0, 0, 0);        // R7
            do_req(8'd255, 8'd255, 2'(r), 1'b1, 1'b0, 0, 0, 0);        // R7
            do_req(8'd17, 8'd33, 2'(r), 1'b1, 1'b0, 0, 0, 0);          // R5 R6
        end

        // Request held through the final handshake (R9 R10)
        do_req(8'd100, 8'd50, 2'd1, 1'b1, 1'b1, 8'd3, 8'd200, 2'd2);
        do_req(8'd3, 8'd200, 2'd2, 1'b1, 1'b1, 8'd250, 8'd7, 2'd3);
        do_req(8'd250, 8'd7, 2'd3, 1'b0, 1'b0, 0, 0, 0);

        // Constrained random requests, some chained
        for (int n = 0; n < 80; n++) begin
            logic [7:0] ax, ay;
            logic [1:0] ar;
            ax = 8'($urandom); ay = 8'($urandom); ar = 2'($urandom);
            do_req(ax, ay, ar, 1'($urandom % 2), 1'b0, 0, 0, 0);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule